// File: doc/BRIEF.md
# Delayed Issue Queue

This block sits between bundle decode and a single functional unit of a wide-issue machine. Each operation that decode steers to the unit arrives with a small issue delay chosen by the compiler. The block holds a time-slotted queue in which slot k stands for "issue k cycles from now". An incoming operation is written into the slot that matches its delay, and the unit is handed whatever sits in slot 0. The unit never searches the queue. Operations reach the unit out of program order only because their delays differ, so no wakeup or select logic is needed. One instance serves each unit, and the instances together form the issue stage.

On a slot collision, the operation moves to the nearest free slot later than the one it asked for. Work decoded earlier therefore keeps its place ahead of it. An operation with delay 0 that finds slot 0 empty is passed straight through to the unit in the same cycle. Both sides are valid/ready streams:
- **Input side.** `in_ready` is high only when a slot is free at or after the requested delay. Its value depends on `in_delay`. Decode holds `in_op` and `in_delay` stable while `in_valid` is high and `in_ready` is low.
- **Output side.** The unit may hold off by driving `out_ready` low. While `out_valid` is high and `out_ready` is low, the whole queue freezes, so the spacing between pending operations is kept.

`flush` empties the queue, for use on a redirect.

Top module: `delayed_issue_queue`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 for any `in_delay`.
- R2: An accepted operation with delay 0 that finds slot 0 empty appears on `out_op` with `out_valid` high in its own acceptance cycle.
- R3: With no collision and `out_ready` held high, an operation accepted in cycle t with delay d is presented in cycle t+d. Operations whose slots are in the reverse of their arrival order are presented in slot order.
- R4: If the requested slot is occupied, the operation takes the lowest-numbered free slot above it. It never issues ahead of an operation already queued at an earlier slot.
- R5: Every delay from 0 to SLOTS-1 (0 to 7 by default) is honoured. This includes a collision at the largest delay, which is resolved into the last slot.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_op` holds and no slot advances. Pending operations issue later by exactly the number of frozen cycles.
- R7: `in_ready` is 0, and the operation is not taken, exactly when every slot from `in_delay` up to the last is occupied. A smaller delay that reaches a free slot is accepted.
- R8: While `flush` is high, `out_valid` and `in_ready` are 0, and the incoming operation is ignored. After flush, no earlier operation ever issues and the queue starts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties every slot |
| in_valid | input | 1 | Decode offers an operation |
| in_ready | output | 1 | Operation accepted this cycle |
| in_op | input | OP_W | Operation word |
| in_delay | input | $clog2(SLOTS) | Requested issue delay in cycles |
| out_valid | output | 1 | Operation presented to the unit |
| out_ready | input | 1 | Unit takes the presented operation |
| out_op | output | OP_W | Operation word to the unit |

## Verification
The bench drives cases whose expected issue cycles depend on slot arithmetic:
- **Reordered pair and three-way collision.** A design that appended at the tail would issue in arrival order. A design that dropped the collision rule would overwrite a queued operation or issue the colliding ones early.
- **Unit hold-off while the last slot fills.** A design that kept shifting during the hold would lose the held operation or shift every later issue cycle. A wrong stall test would either accept into an occupied slot or refuse a smaller delay that still fits.
- **Flush with queued operations and a delay-0 offer in the same cycle.** This catches stale issues after flush and a bypass that leaks through it.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int DQ_DEF_SLOTS = 8;
  localparam int DQ_DEF_OP_W  = 16;

  // queue motion for one cycle
  typedef enum logic {
    Q_SHIFT = 1'b0,
    Q_HOLD  = 1'b1
  } dq_step_e;
endpackage

// File: rtl/dq_slot_finder.sv
module dq_slot_finder #(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] occ,
  input  logic [IDX_W-1:0] dly,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  logic [SLOTS-1:0] cand;

  // a slot qualifies when free and not earlier than the requested delay
  for (genvar j = 0; j < SLOTS; j++) begin : g_cand
    assign cand[j] = !occ[j] && (int'(dly) <= j);
  end

  // lowest qualifying slot wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (cand[j]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/dq_slot_array.sv
module dq_slot_array
  import dq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int OP_W  = 16,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  dq_step_e         step,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OP_W-1:0]  wr_op,
  output logic [SLOTS-1:0] occ,
  output logic             head_v,
  output logic [OP_W-1:0]  head_op
);
  logic [SLOTS-1:0] vld_q, wv, nv;
  logic [OP_W-1:0]  op_q [SLOTS];
  logic [OP_W-1:0]  wop  [SLOTS];
  logic [OP_W-1:0]  nop  [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic hit;
    assign hit    = wr_en && (wr_idx == IDX_W'(k));
    assign wv[k]  = vld_q[k] | hit;
    assign wop[k] = hit ? wr_op : op_q[k];
    if (k == SLOTS - 1) begin : g_last
      // nothing lies beyond the last slot, so it empties on a shift
      assign nv[k]  = (step == Q_HOLD) ? wv[k]  : 1'b0;
      assign nop[k] = (step == Q_HOLD) ? wop[k] : '0;
    end else begin : g_mid
      assign nv[k]  = (step == Q_HOLD) ? wv[k]  : wv[k+1];
      assign nop[k] = (step == Q_HOLD) ? wop[k] : wop[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) vld_q <= '0;
    else              vld_q <= nv;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) op_q[k] <= nop[k];
  end

  assign occ     = vld_q;
  assign head_v  = vld_q[0];
  assign head_op = op_q[0];
endmodule

// File: rtl/dq_head_sel.sv
module dq_head_sel #(
  parameter int OP_W = 16
) (
  input  logic            flush,
  input  logic            head_v,
  input  logic [OP_W-1:0] head_op,
  input  logic            byp_v,
  input  logic [OP_W-1:0] byp_op,
  output logic            out_valid,
  output logic [OP_W-1:0] out_op
);
  // queued head has precedence; bypass only when slot 0 was empty
  always_comb begin
    out_valid = 1'b0;
    out_op    = head_op;
    if (!flush) begin
      if (head_v) begin
        out_valid = 1'b1;
      end else if (byp_v) begin
        out_valid = 1'b1;
        out_op    = byp_op;
      end
    end
  end
endmodule

// File: rtl/delayed_issue_queue.sv
module delayed_issue_queue
  import dq_pkg::*;
#(
  parameter int SLOTS = DQ_DEF_SLOTS,
  parameter int OP_W  = DQ_DEF_OP_W,
  localparam int DLY_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [DLY_W-1:0] in_delay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op
);
  logic [SLOTS-1:0] occ;
  logic             head_v;
  logic [OP_W-1:0]  head_op;
  logic             found;
  logic [DLY_W-1:0] pick;
  logic             accept;
  logic             bypass;
  dq_step_e         step;

  dq_slot_finder #(.SLOTS(SLOTS)) u_find (
    .occ   (occ),
    .dly   (in_delay),
    .found (found),
    .pick  (pick)
  );

  assign in_ready = found && !flush;
  assign accept   = in_valid && in_ready;
  assign bypass   = accept && (pick == '0);

  dq_head_sel #(.OP_W(OP_W)) u_head (
    .flush     (flush),
    .head_v    (head_v),
    .head_op   (head_op),
    .byp_v     (bypass),
    .byp_op    (in_op),
    .out_valid (out_valid),
    .out_op    (out_op)
  );

  // a presented but refused operation freezes every slot
  assign step = (out_valid && !out_ready) ? Q_HOLD : Q_SHIFT;

  dq_slot_array #(.SLOTS(SLOTS), .OP_W(OP_W)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .step    (step),
    .wr_en   (accept),
    .wr_idx  (pick),
    .wr_op   (in_op),
    .occ     (occ),
    .head_v  (head_v),
    .head_op (head_op)
  );
endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
  parameter int SLOTS = 8,
  parameter int OP_W  = 16,
  localparam int DLY_W = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_op,
  input logic [DLY_W-1:0] in_delay,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OP_W-1:0]  out_op,
  input logic [SLOTS-1:0] occ
);
  // R2
  bypass_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_delay == '0) |-> (out_valid && (occ[0] || out_op == in_op)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (flush || (out_valid && out_op == $past(out_op))));

  // R7
  stall_reason_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !flush) |-> occ[in_delay]);

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!out_valid && !in_ready));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0));
endmodule

bind delayed_issue_queue dq_checker #(.SLOTS(SLOTS), .OP_W(OP_W)) u_dq_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_delay  (in_delay),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .occ       (occ)
);

// File: tb/tb_delayed_issue_queue.sv
`timescale 1ns/1ps
module tb_delayed_issue_queue;
  localparam int SLOTS = 8;
  localparam int OP_W  = 16;
  localparam int DW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [OP_W-1:0] in_op = '0;
  logic [DW-1:0] in_delay = '0;
  logic in_ready, out_valid;
  logic [OP_W-1:0] out_op;

  delayed_issue_queue #(.SLOTS(SLOTS), .OP_W(OP_W)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_delay(in_delay),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_op [int];
  string exp_tag [int];

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step();
      in_valid = 1'b0;
    end
  endtask

  // offers one operation; issue_at < 0 means no issue is expected
  task automatic send(int op, int d, int issue_at, string tag);
    step();
    in_valid = 1'b1;
    in_op    = OP_W'(op);
    in_delay = DW'(d);
    if (issue_at >= 0) begin
      exp_op[cyc + issue_at]  = op;
      exp_tag[cyc + issue_at] = tag;
    end
    @(negedge clk);
    check(in_ready == 1'b1, tag, "in_ready on offer", int'(in_ready), 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid && out_ready) begin
        if (exp_op.exists(cyc)) begin
          check(int'(out_op) == exp_op[cyc], exp_tag[cyc], "issued opcode", int'(out_op), exp_op[cyc]);
          exp_op.delete(cyc);
          exp_tag.delete(cyc);
        end else begin
          check(1'b0, "R3", "unexpected issue opcode", int'(out_op), -1);
        end
      end else if (exp_op.exists(cyc)) begin
        check(1'b0, exp_tag[cyc], "missing issue opcode", -1, exp_op[cyc]);
        exp_op.delete(cyc);
        exp_tag.delete(cyc);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL all watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2 same-cycle bypass
    send('h11, 0, 0, "R2");
    idle(2);

    // R3 reordering: later-decoded op issues first
    send('hA1, 3, 3, "R3");
    send('hA2, 0, 0, "R3");
    idle(5);
    send('hB1, 0, 0, "R3");
    send('hB2, 3, 3, "R3");
    idle(5);

    // R4 three-way collision
    send('hC1, 3, 3, "R4");
    send('hC2, 2, 3, "R4");
    send('hC3, 1, 3, "R4");
    idle(6);

    // R5 largest delay, then collision into the last slot
    send('hD1, 7, 7, "R5");
    send('hD2, 6, 7, "R5");
    idle(10);

    // R6 / R7 hold-off and stall
    step();
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 'hE1; in_delay = 0;
    c0 = cyc;
    exp_op[c0 + 4] = 'hE1; exp_tag[c0 + 4] = "R6";
    @(negedge clk);
    check(out_valid && out_op == 'hE1, "R6", "held head opcode", int'(out_op), 'hE1);
    step();
    in_op = 'hE2; in_delay = 7;
    exp_op[c0 + 11] = 'hE2; exp_tag[c0 + 11] = "R6";
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "last slot free", int'(in_ready), 1);
    check(out_valid && out_op == 'hE1, "R6", "held head opcode", int'(out_op), 'hE1);
    step();
    in_op = 'hE3; in_delay = 7;
    @(negedge clk);
    check(in_ready == 1'b0, "R7", "stall when slots full from delay", int'(in_ready), 0);
    check(out_valid && out_op == 'hE1, "R6", "held head opcode", int'(out_op), 'hE1);
    step();
    in_op = 'hE3; in_delay = 5;
    exp_op[c0 + 9] = 'hE3; exp_tag[c0 + 9] = "R7";
    @(negedge clk);
    check(in_ready == 1'b1, "R7", "smaller delay accepted", int'(in_ready), 1);
    step();
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(9);

    // R8 flush drops queued work and ignores the offer
    send('hF1, 4, -1, "R8");
    send('hF2, 6, -1, "R8");
    step();
    flush = 1'b1;
    in_valid = 1'b1; in_op = 'hF3; in_delay = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid during flush", int'(out_valid), 0);
    check(in_ready == 1'b0, "R8", "in_ready during flush", int'(in_ready), 0);
    step();
    flush = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "quiet after flush", int'(out_valid), 0);
      step();
    end
    send('h12, 2, 2, "R8");
    idle(4);

    check(exp_op.num() == 0, "R3", "outstanding expected issues", exp_op.num(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule